// File: doc/BRIEF.md
# Pinball Score Display Decoder

This block turns two bytes written by a processor into segment words for a multiplexed pinball score display. The first byte, the digit byte, is kept in a latch. Its low nibble is a BCD code and its top bit is an active-low request to light the split centre '1'. The second byte, the control byte, asks for one digit update. Its bits 6:4 pick a display group and its low nibble picks a digit within that group.

One clock after each accepted control write, the block gives a one-cycle valid pulse. With the pulse it gives a flat digit index and a 10-bit segment word. Player digits use a widened format. In that format the two middle segments are doubled, and a separate pair of centre segments can show a '1'. Credit and ball digits use the plain 7-bit pattern. An FSM sequences the output with two states. ST_IDLE drives no update. ST_SHOW presents the update. Three transitions are named: GO_SHOW (ST_IDLE to ST_SHOW on an accepted write), STAY_SHOW (ST_SHOW to ST_SHOW on another accepted write) and GO_IDLE (ST_SHOW to ST_IDLE when no write is accepted).

Top module: `scoredisp_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, upd_valid is 0 and the digit latch holds 0x00. The first credits-group update after reset therefore shows 0x006.
- R2: The digit byte is captured on every cycle with dig_we high. It holds its value through any number of control writes.
- R3: Code-to-pattern table, segment a in bit 0 up to g in bit 6: 0→3F, 1→06, 2→5B, 3→4F, 4→66, 5→6D, 6→7C, 7→07, 8→7F, 9→67, A→58, B→4C, C→62, D→69, E→78, F→00.
- R4: A control write is accepted only when bits 6:4 equal 001 (players 1/2), 010 (players 3/4) or 100 (credits/balls). Any other value produces no valid pulse.
- R5: upd_index equals the control byte's low nibble, plus 0 for players 1/2, 20 for players 3/4 or 40 for credits/balls.
- R6: For player groups the output word is widened: bits 5:0 equal pattern bits 5:0, bits 7 and 6 both equal pattern bit 6, and bits 9:8 follow pattern bit 7, which the table leaves at 0.
- R7: For player groups, when bit 7 of the latched digit byte is 0, bits 9:8 of the word are both set (centre '1').
- R8: For the credits group, digit-byte bit 7 = 0 shows the pattern of code 1 (0x006). Bit 7 = 1 shows the plain pattern of the latched code, with bits 9:7 at 0.
- R9: upd_valid rises exactly one cycle after an accepted control write and lasts one cycle per write. Back-to-back writes give back-to-back pulses.
- R10: When the digit byte and the control byte are written in the same cycle, the update uses the digit byte that was latched before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dig_we | input | 1 | Digit byte write strobe |
| dig_byte | input | 8 | BCD code [3:0], centre control [6:4], active-low centre '1' [7] |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_byte | input | 8 | Digit number [3:0], group select [6:4] |
| upd_valid | output | 1 | One-cycle update strobe |
| upd_index | output | 6 | Flat digit address |
| upd_seg | output | 10 | Segment word |

## Verification
Every result is due one clock after the control write that asks for it. The digit latch takes effect one clock after its own write. An update issued in that same clock still sees the older digit byte. The reference model follows this timing. On each rising edge it computes the expected pulse, index and word from the inputs held across that edge and the model's previous latch, and only after that does it update the latch. The outputs are compared at the following falling edge, on every cycle. The directed sequences sample at the falling edge that follows the cycle in which the write strobe was high.

// File: rtl/scoredisp_pkg.sv
package scoredisp_pkg;
    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_P12  = 2'd1,
        GRP_P34  = 2'd2,
        GRP_CRED = 2'd3
    } grp_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } st_e;

    localparam int SEG7_W = 7;

    // group field is one-hot; anything else selects no group
    function automatic grp_e group_of(input logic [2:0] sel);
        unique case (sel)
            3'b001:  return GRP_P12;
            3'b010:  return GRP_P34;
            3'b100:  return GRP_CRED;
            default: return GRP_NONE;
        endcase
    endfunction
endpackage

// File: rtl/seg_rom.sv
module seg_rom
    import scoredisp_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [SEG7_W-1:0] pat
);
    always_comb begin
        unique case (code[3:0])
            4'h0: pat = 7'h3F;
            4'h1: pat = 7'h06;
            4'h2: pat = 7'h5B;
            4'h3: pat = 7'h4F;
            4'h4: pat = 7'h66;
            4'h5: pat = 7'h6D;
            4'h6: pat = 7'h7C;
            4'h7: pat = 7'h07;
            4'h8: pat = 7'h7F;
            4'h9: pat = 7'h67;
            4'hA: pat = 7'h58;
            4'hB: pat = 7'h4C;
            4'hC: pat = 7'h62;
            4'hD: pat = 7'h69;
            4'hE: pat = 7'h78;
            default: pat = 7'h00;
        endcase
    end
endmodule

// File: rtl/seg_format.sv
module seg_format
    import scoredisp_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int SEG_W  = 10
) (
    input  grp_e             grp,
    input  logic [7:0]       dig,
    output logic [SEG_W-1:0] seg
);
    localparam int PASS_W = SEG7_W - 1;

    logic              one_n;
    logic [CODE_W-1:0] code_sel;
    logic [SEG7_W-1:0] pat;
    logic [7:0]        pat8;
    logic [SEG_W-1:0]  wide;
    logic [SEG_W-1:0]  narrow;

    assign one_n = dig[7];

    // credits group swaps in code 1 when the centre-one bit is low
    assign code_sel = (grp == GRP_CRED && !one_n) ? CODE_W'(1) : dig[CODE_W-1:0];

    seg_rom #(.CODE_W(CODE_W)) u_rom (
        .code (code_sel),
        .pat  (pat)
    );

    assign pat8 = {1'b0, pat};

    genvar gi;
    generate
        for (gi = 0; gi < PASS_W; gi++) begin : g_pass
            assign wide[gi] = pat8[gi];
        end
    endgenerate

    // middle stroke doubled, top pair carries bit 7 or the centre one
    assign wide[PASS_W]   = pat8[PASS_W];
    assign wide[PASS_W+1] = pat8[PASS_W];
    assign wide[SEG_W-2]  = pat8[7] | ~one_n;
    assign wide[SEG_W-1]  = pat8[7] | ~one_n;

    assign narrow = SEG_W'(pat);

    always_comb begin
        unique case (grp)
            GRP_P12, GRP_P34: seg = wide;
            default:          seg = narrow;
        endcase
    end
endmodule

// File: rtl/digit_addr.sv
module digit_addr
    import scoredisp_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int STRIDE  = 20,
    parameter int INDEX_W = 6
) (
    input  grp_e               grp,
    input  logic [CODE_W-1:0]  digit,
    output logic [INDEX_W-1:0] index
);
    logic [INDEX_W-1:0] base;

    always_comb begin
        unique case (grp)
            GRP_P34:  base = INDEX_W'(STRIDE);
            GRP_CRED: base = INDEX_W'(2 * STRIDE);
            default:  base = '0;
        endcase
    end

    assign index = base + INDEX_W'(digit);
endmodule

// File: rtl/scoredisp_decoder.sv
module scoredisp_decoder
    import scoredisp_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int SEG_W   = 10,
    parameter int STRIDE  = 20,
    parameter int INDEX_W = $clog2(2 * STRIDE + (1 << CODE_W))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dig_we,
    input  logic [7:0]         dig_byte,
    input  logic               ctl_we,
    input  logic [7:0]         ctl_byte,
    output logic               upd_valid,
    output logic [INDEX_W-1:0] upd_index,
    output logic [SEG_W-1:0]   upd_seg
);
    localparam int MAX_INDEX = 2 * STRIDE + (1 << CODE_W) - 1;

    st_e                state_q, state_d;
    logic [7:0]         dig_q;
    grp_e               grp;
    logic               accept;
    logic [SEG_W-1:0]   seg_c;
    logic [INDEX_W-1:0] idx_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dig_q <= '0;
        else if (dig_we) dig_q <= dig_byte;
    end

    assign grp    = group_of(ctl_byte[6:4]);
    assign accept = ctl_we && (grp != GRP_NONE);

    seg_format #(.CODE_W(CODE_W), .SEG_W(SEG_W)) u_fmt (
        .grp (grp),
        .dig (dig_q),
        .seg (seg_c)
    );

    digit_addr #(.CODE_W(CODE_W), .STRIDE(STRIDE), .INDEX_W(INDEX_W)) u_addr (
        .grp   (grp),
        .digit (ctl_byte[CODE_W-1:0]),
        .index (idx_c)
    );

    // next state: GO_SHOW, STAY_SHOW, GO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)  state_d = ST_SHOW;
            ST_SHOW: if (!accept) state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_index <= '0;
            upd_seg   <= '0;
        end else if (accept) begin
            upd_index <= idx_c;
            upd_seg   <= seg_c;
        end
    end

    assign upd_valid = (state_q == ST_SHOW);

    // R9: accepted write yields a pulse on the next cycle
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && (ctl_byte[6:4] == 3'b001 || ctl_byte[6:4] == 3'b010 ||
                    ctl_byte[6:4] == 3'b100)) |=> upd_valid);

    // R4: no accepted write, no pulse
    p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_we && (ctl_byte[6:4] == 3'b001 || ctl_byte[6:4] == 3'b010 ||
                     ctl_byte[6:4] == 3'b100)) |=> !upd_valid);

    // R5: index stays inside the addressed range
    p_index_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (int'(upd_index) <= MAX_INDEX));

    // R6: player words carry the doubled middle stroke
    p_stripe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && int'(upd_index) < 2 * STRIDE) |-> (upd_seg[6] == upd_seg[7]));

    // R8: credit words are never widened
    p_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && int'(upd_index) >= 2 * STRIDE) |-> (upd_seg[SEG_W-1:7] == '0));

    // R2: latch changes only on a digit write
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dig_we |=> $stable(dig_q));
endmodule

// File: tb/test_scoredisp_decoder.sv
module test_scoredisp_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dig_we = 1'b0;
    logic [7:0] dig_byte = '0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_byte = '0;
    logic       upd_valid;
    logic [5:0] upd_index;
    logic [9:0] upd_seg;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scoredisp_decoder i_scoredisp_decoder (
        .clk(clk), .rst_n(rst_n), .dig_we(dig_we), .dig_byte(dig_byte),
        .ctl_we(ctl_we), .ctl_byte(ctl_byte),
        .upd_valid(upd_valid), .upd_index(upd_index), .upd_seg(upd_seg)
    );

    function automatic int tab(input int c);
        int t[16] = '{'h3F, 'h06, 'h5B, 'h4F, 'h66, 'h6D, 'h7C, 'h07,
                      'h7F, 'h67, 'h58, 'h4C, 'h62, 'h69, 'h78, 'h00};
        return t[c & 15];
    endfunction

    function automatic int grp_of(input int c);
        int s = (c >> 4) & 7;
        if (s == 1) return 1;
        if (s == 2) return 2;
        if (s == 4) return 3;
        return 0;
    endfunction

    function automatic int ref_seg(input int g, input int d);
        int p, w;
        if (g == 3) return ((d & 'h80) != 0) ? tab(d) : tab(1);
        p = tab(d);
        w = p & 'h3F;
        if ((p >> 6) & 1) w = w | 'hC0;
        if ((p >> 7) & 1) w = w | 'h300;
        if ((d & 'h80) == 0) w = w | 'h300;
        return w;
    endfunction

    // behavioural reference model
    int ref_latch;
    bit exp_valid;
    int exp_index, exp_seg, exp_grp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_latch <= 0; exp_valid <= 0; exp_index <= 0; exp_seg <= 0; exp_grp <= 0;
        end else begin
            int g;
            g = grp_of(ctl_byte);
            exp_valid <= ctl_we && g != 0;
            if (ctl_we && g != 0) begin
                exp_grp   <= g;
                exp_index <= (ctl_byte & 15) + 20 * (g - 1);
                exp_seg   <= ref_seg(g, ref_latch);
            end
            if (dig_we) ref_latch <= dig_byte;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!done) begin
            chk(upd_valid == exp_valid, "R9/R4 valid", upd_valid, exp_valid);
            if (exp_valid) begin
                chk(int'(upd_index) == exp_index, "R5 index", upd_index, exp_index);
                chk(int'(upd_seg) == exp_seg, exp_grp == 3 ? "R8 credit word" : "R6/R7 player word",
                    upd_seg, exp_seg);
            end
        end
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic put_dig(input int d);
        @(negedge clk); dig_we = 1; dig_byte = 8'(d);
        @(negedge clk); dig_we = 0;
    endtask

    // drives a control write; returns sampled outputs one cycle later
    task automatic put_ctl(input int c, output bit v, output int idx, output int sg);
        @(negedge clk); ctl_we = 1; ctl_byte = 8'(c);
        @(negedge clk); ctl_we = 0;
        #1; v = upd_valid; idx = upd_index; sg = upd_seg;
    endtask

    initial begin
        bit v; int idx, sg;
        repeat (3) @(negedge clk);
        chk(upd_valid == 0, "R1 valid in reset", upd_valid, 0);
        rst_n = 1;
        @(negedge clk);
        chk(upd_valid == 0, "R1 valid after reset", upd_valid, 0);
        put_ctl('h43, v, idx, sg);
        chk(v == 1 && sg == 'h006, "R1 cleared latch shows one", sg, 'h006);
        chk(idx == 43, "R5 credits offset", idx, 43);

        // R3: every code through the plain credits path
        for (int c = 0; c < 16; c++) begin
            put_dig('h80 | c);
            put_ctl('h40 | c, v, idx, sg);
            chk(sg == tab(c), "R3 table", sg, tab(c));
        end

        // R6 widening without centre one, R7 with it
        put_dig('h88);
        put_ctl('h15, v, idx, sg);
        chk(sg == 'hFF && idx == 5, "R6 widened eight", sg, 'hFF);
        put_dig('h08);
        put_ctl('h27, v, idx, sg);
        chk(sg == 'h3FF && idx == 27, "R7 centre one", sg, 'h3FF);
        put_dig('h0F);
        put_ctl('h20, v, idx, sg);
        chk(sg == 'h300, "R7 centre one on blank", sg, 'h300);
        put_dig('h09);
        put_ctl('h4A, v, idx, sg);
        chk(sg == 'h006 && idx == 50, "R8 credit one override", sg, 'h006);

        // R4: invalid selects
        for (int s = 0; s < 8; s++) begin
            if (s == 1 || s == 2 || s == 4) continue;
            put_ctl(s << 4, v, idx, sg);
            chk(v == 0, "R4 invalid group ignored", v, 0);
        end

        // R2: latch holds across control writes
        put_dig('h83);
        for (int k = 0; k < 3; k++) begin
            put_ctl('h40 | k, v, idx, sg);
            chk(sg == 'h4F, "R2 latch holds", sg, 'h4F);
        end

        // R10: same-cycle write uses old byte
        @(negedge clk); dig_we = 1; dig_byte = 8'h85; ctl_we = 1; ctl_byte = 8'h41;
        @(negedge clk); dig_we = 0; ctl_we = 0;
        #1; chk(upd_seg == 10'h04F, "R10 old byte used", upd_seg, 'h4F);
        put_ctl('h41, v, idx, sg);
        chk(sg == 'h6D, "R10 new byte next", sg, 'h6D);

        // R9: back-to-back writes
        @(negedge clk); ctl_we = 1; ctl_byte = 8'h11;
        @(negedge clk); ctl_byte = 8'h22;
        #1; chk(upd_valid == 1 && upd_index == 1, "R9 first of pair", upd_index, 1);
        @(negedge clk); ctl_we = 0;
        #1; chk(upd_valid == 1 && upd_index == 22, "R9 second of pair", upd_index, 22);
        @(negedge clk);
        #1; chk(upd_valid == 0, "R9 single pulse", upd_valid, 0);

        // random traffic checked by the model
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            dig_we   = ($urandom % 3) == 0;
            dig_byte = 8'($urandom);
            ctl_we   = ($urandom % 2) == 0;
            ctl_byte = 8'($urandom);
        end
        @(negedge clk); dig_we = 0; ctl_we = 0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule